// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block sits at the head of a reorder buffer and decides, every cycle, how many of the oldest entries leave the buffer. It looks at a window of head entries, each described by its valid, squashed, executed, fault, store, load and non-speculative flags and its sequence number. Entries are removed strictly in order. Removal stops at the first entry that is not ready or may not retire yet. The removal vector is combinational, so the buffer can pop the entries in the same cycle.

Some entries cannot retire in the normal way: serialising and barrier instructions that have not executed, loads that have not executed (handled as uncached), and faulting instructions. Such an entry acts only when it is the first instruction to commit in the cycle and no stores are waiting to write back. It then sends one request back to earlier stages: execute it non-speculatively, replay it, or take a trap. The block also reports free-entry count updates, an empty indication, the youngest committed sequence number, and a program counter that advances with each commit.

Top module: `retire_ctrl`

## Requirements
- R1: At most CW (default 4) non-squashed instructions commit per cycle. The removed entries form a contiguous run from slot 0, where bit i of `retire_o` is slot i. The run ends at the first slot that is invalid, unexecuted, faulting, or past the commit limit.
- R2: A valid squashed entry is removed without counting toward CW. A window of 2 squashed and 4 executed entries therefore removes all 6.
- R3: An unexecuted entry with the non-speculative flag raises `nspec_req_o` one cycle later, with its sequence number on `req_seq_o`, and is not removed. This happens only when no instruction committed before it in that cycle and `stores_pending_i` is low. Otherwise it stalls silently.
- R4: An unexecuted load under the same condition raises `replay_req_o` with its sequence number. If an entry carries both the load and non-speculative flags, the non-speculative request wins.
- R5: A faulting entry (executed or not) raises `trap_req_o` with its sequence number under the same first-commit and no-store condition, and is not removed. Squashed removals ahead of it do not break the first-commit condition. `trap_pend_o` then rises. While it is high, nothing is removed. A cycle with `trap_done_i` high returns the block to normal operation from the next cycle on.
- R6: After a cycle with k commits, `pc_o` has advanced by k*INSN_BYTES, and `npc_o` always equals `pc_o + INSN_BYTES`. `pc_o` starts at RESET_PC.
- R7: One cycle after a scan, `empty_o` is high only if `rob_used_i` minus the removed count is zero, `stores_pending_i` is low, and no store committed in that cycle.
- R8: `free_upd_o` pulses one cycle after any cycle that removed entries, with `free_cnt_o = DEPTH - (rob_used_i - removed)`. In every other cycle `free_cnt_o` holds its value. After reset it is DEPTH.
- R9: `done_vld_o` pulses one cycle after any commit, and `done_seq_o` then carries the sequence number of the youngest committed instruction. `done_seq_o` holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| head_vld_i | input | SLOTS | Slot holds an entry |
| head_sq_i | input | SLOTS | Entry is squashed |
| head_exec_i | input | SLOTS | Entry has executed |
| head_fault_i | input | SLOTS | Entry carries a fault |
| head_store_i | input | SLOTS | Entry is a store |
| head_load_i | input | SLOTS | Entry is a load |
| head_nspec_i | input | SLOTS | Entry is serialising, store-conditional or barrier |
| head_seq_i | input | SLOTS*SEQ_W | Sequence numbers, slot i at bits i*SEQ_W upward |
| rob_used_i | input | CNT_W | Buffer occupancy before this cycle's removal |
| stores_pending_i | input | 1 | Write-back logic still holds stores |
| trap_done_i | input | 1 | Trap handling finished |
| retire_o | output | SLOTS | Entries removed this cycle (combinational) |
| nspec_req_o | output | 1 | Non-speculative execute request |
| replay_req_o | output | 1 | Uncached load replay request |
| trap_req_o | output | 1 | Trap request |
| req_seq_o | output | SEQ_W | Sequence number for the active request |
| trap_pend_o | output | 1 | Thread waiting for trap handling |
| free_upd_o | output | 1 | Free-entry count updated |
| free_cnt_o | output | CNT_W | Free entries |
| empty_o | output | 1 | Buffer empty and store path quiet |
| done_vld_o | output | 1 | Commits happened last cycle |
| done_seq_o | output | SEQ_W | Youngest committed sequence number |
| pc_o | output | PC_W | Committed program counter |
| npc_o | output | PC_W | Next program counter |

## Verification
The hardest case to reach is the first-commit rule. A special entry must act when only squashed entries precede it, and must stay silent when a committed instruction precedes it, all within one window. The stimulus places a squashed entry ahead of a faulting one, and separately an executed entry ahead of a non-speculative or faulting one. It also drives a store commit that empties the buffer, to show the empty indication being held back for that one cycle, and enters and leaves the trap-pending state while ready entries are present.

// File: rtl/retire_pkg.sv
`timescale 1ns/1ps
package retire_pkg;
  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_NSPEC  = 2'd1,
    REQ_REPLAY = 2'd2,
    REQ_TRAP   = 2'd3
  } req_kind_e;

  typedef enum logic {
    TH_RUN  = 1'b0,
    TH_TRAP = 1'b1
  } th_state_e;
endpackage

// File: rtl/retire_scan.sv
`timescale 1ns/1ps
module retire_scan import retire_pkg::*; #(
  parameter int SLOTS = 6,
  parameter int CW    = 4,
  parameter int SEQ_W = 16,
  localparam int NC_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]       vld_i,
  input  logic [SLOTS-1:0]       sq_i,
  input  logic [SLOTS-1:0]       exec_i,
  input  logic [SLOTS-1:0]       fault_i,
  input  logic [SLOTS-1:0]       store_i,
  input  logic [SLOTS-1:0]       load_i,
  input  logic [SLOTS-1:0]       nspec_i,
  input  logic [SLOTS*SEQ_W-1:0] seq_i,
  input  logic                   stores_pending_i,
  input  logic                   blocked_i,
  output logic [SLOTS-1:0]       retire_o,
  output logic [SLOTS-1:0]       commit_o,
  output logic [NC_W-1:0]        ncommit_o,
  output logic [NC_W-1:0]        nretire_o,
  output logic                   st_commit_o,
  output logic [SEQ_W-1:0]       young_seq_o,
  output req_kind_e              req_kind_o,
  output logic [SEQ_W-1:0]       req_seq_o
);
  always_comb begin
    logic go;
    logic first_ok;
    go          = !blocked_i;
    retire_o    = '0;
    commit_o    = '0;
    ncommit_o   = '0;
    nretire_o   = '0;
    st_commit_o = 1'b0;
    young_seq_o = '0;
    req_kind_o  = REQ_NONE;
    req_seq_o   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      first_ok = (ncommit_o == '0) && !stores_pending_i;
      if (go) begin
        if (ncommit_o == NC_W'(CW) || !vld_i[i]) begin
          go = 1'b0;
        end else if (sq_i[i]) begin
          retire_o[i] = 1'b1;
          nretire_o   = nretire_o + 1'b1;
        end else if (exec_i[i] && !fault_i[i]) begin
          retire_o[i] = 1'b1;
          commit_o[i] = 1'b1;
          nretire_o   = nretire_o + 1'b1;
          ncommit_o   = ncommit_o + 1'b1;
          young_seq_o = seq_i[i*SEQ_W +: SEQ_W];
          if (store_i[i]) st_commit_o = 1'b1;
        end else begin
          // special head: acts only as first commit with a quiet store path
          if (first_ok) begin
            if (fault_i[i])      req_kind_o = REQ_TRAP;
            else if (nspec_i[i]) req_kind_o = REQ_NSPEC;
            else if (load_i[i])  req_kind_o = REQ_REPLAY;
            req_seq_o = seq_i[i*SEQ_W +: SEQ_W];
          end
          go = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/retire_pc.sv
`timescale 1ns/1ps
module retire_pc #(
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h100,
  parameter int          NC_W       = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NC_W-1:0] ncommit_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  logic [PC_W-1:0] step;
  assign step = PC_W'(ncommit_i) * PC_W'(INSN_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= PC_W'(RESET_PC);
      npc_o <= PC_W'(RESET_PC) + PC_W'(INSN_BYTES);
    end else begin
      pc_o  <= pc_o + step;
      npc_o <= npc_o + step;
    end
  end

  p_npc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npc_o == pc_o + PC_W'(INSN_BYTES));
endmodule

// File: rtl/retire_occ.sv
`timescale 1ns/1ps
module retire_occ #(
  parameter int DEPTH = 32,
  parameter int NC_W  = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] used_i,
  input  logic [NC_W-1:0]  nretire_i,
  input  logic             stores_pending_i,
  input  logic             st_commit_i,
  output logic             free_upd_o,
  output logic [CNT_W-1:0] free_cnt_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] remain;
  assign remain = used_i - CNT_W'(nretire_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_upd_o <= 1'b0;
      free_cnt_o <= CNT_W'(DEPTH);
      empty_o    <= 1'b1;
    end else begin
      free_upd_o <= (nretire_i != '0);
      if (nretire_i != '0) free_cnt_o <= CNT_W'(DEPTH) - remain;
      // a store committing this cycle has not reached write-back yet
      empty_o <= (remain == '0) && !stores_pending_i && !st_commit_i;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !free_upd_o |-> $stable(free_cnt_o));
  p_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> !$past(stores_pending_i) && !$past(st_commit_i));
endmodule

// File: rtl/retire_ctrl.sv
`timescale 1ns/1ps
module retire_ctrl import retire_pkg::*; #(
  parameter int          SLOTS      = 6,
  parameter int          CW         = 4,
  parameter int          SEQ_W      = 16,
  parameter int          DEPTH      = 32,
  parameter int          PC_W       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] RESET_PC   = 32'h100,
  localparam int         CNT_W      = $clog2(DEPTH + 1),
  localparam int         NC_W       = $clog2(SLOTS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [SLOTS-1:0]       head_vld_i,
  input  logic [SLOTS-1:0]       head_sq_i,
  input  logic [SLOTS-1:0]       head_exec_i,
  input  logic [SLOTS-1:0]       head_fault_i,
  input  logic [SLOTS-1:0]       head_store_i,
  input  logic [SLOTS-1:0]       head_load_i,
  input  logic [SLOTS-1:0]       head_nspec_i,
  input  logic [SLOTS*SEQ_W-1:0] head_seq_i,
  input  logic [CNT_W-1:0]       rob_used_i,
  input  logic                   stores_pending_i,
  input  logic                   trap_done_i,
  output logic [SLOTS-1:0]       retire_o,
  output logic                   nspec_req_o,
  output logic                   replay_req_o,
  output logic                   trap_req_o,
  output logic [SEQ_W-1:0]       req_seq_o,
  output logic                   trap_pend_o,
  output logic                   free_upd_o,
  output logic [CNT_W-1:0]       free_cnt_o,
  output logic                   empty_o,
  output logic                   done_vld_o,
  output logic [SEQ_W-1:0]       done_seq_o,
  output logic [PC_W-1:0]        pc_o,
  output logic [PC_W-1:0]        npc_o
);
  th_state_e        th_q;
  logic [SLOTS-1:0] commit;
  logic [NC_W-1:0]  ncommit, nretire;
  logic             st_commit;
  logic [SEQ_W-1:0] young_seq, scan_seq;
  req_kind_e        req_kind;

  retire_scan #(.SLOTS(SLOTS), .CW(CW), .SEQ_W(SEQ_W)) u_scan (
    .vld_i            (head_vld_i),
    .sq_i             (head_sq_i),
    .exec_i           (head_exec_i),
    .fault_i          (head_fault_i),
    .store_i          (head_store_i),
    .load_i           (head_load_i),
    .nspec_i          (head_nspec_i),
    .seq_i            (head_seq_i),
    .stores_pending_i (stores_pending_i),
    .blocked_i        (th_q == TH_TRAP),
    .retire_o         (retire_o),
    .commit_o         (commit),
    .ncommit_o        (ncommit),
    .nretire_o        (nretire),
    .st_commit_o      (st_commit),
    .young_seq_o      (young_seq),
    .req_kind_o       (req_kind),
    .req_seq_o        (scan_seq)
  );

  retire_pc #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC),
              .NC_W(NC_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ncommit_i (ncommit),
    .pc_o      (pc_o),
    .npc_o     (npc_o)
  );

  retire_occ #(.DEPTH(DEPTH), .NC_W(NC_W)) u_occ (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .used_i           (rob_used_i),
    .nretire_i        (nretire),
    .stores_pending_i (stores_pending_i),
    .st_commit_i      (st_commit),
    .free_upd_o       (free_upd_o),
    .free_cnt_o       (free_cnt_o),
    .empty_o          (empty_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      th_q         <= TH_RUN;
      nspec_req_o  <= 1'b0;
      replay_req_o <= 1'b0;
      trap_req_o   <= 1'b0;
      req_seq_o    <= '0;
      done_vld_o   <= 1'b0;
      done_seq_o   <= '0;
    end else begin
      if (th_q == TH_TRAP && trap_done_i) th_q <= TH_RUN;
      else if (req_kind == REQ_TRAP)      th_q <= TH_TRAP;
      nspec_req_o  <= (req_kind == REQ_NSPEC);
      replay_req_o <= (req_kind == REQ_REPLAY);
      trap_req_o   <= (req_kind == REQ_TRAP);
      if (req_kind != REQ_NONE) req_seq_o <= scan_seq;
      done_vld_o <= (ncommit != '0);
      if (ncommit != '0) done_seq_o <= young_seq;
    end
  end

  assign trap_pend_o = (th_q == TH_TRAP);

  p_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(commit) <= CW);
  p_prefix_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o & (retire_o + 1'b1)) == '0);
  p_one_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nspec_req_o, replay_req_o, trap_req_o}));
  p_req_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nspec_req_o || replay_req_o || trap_req_o) |-> !$past(stores_pending_i));
  p_trap_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pend_o |-> retire_o == '0);
  p_trap_enter_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> trap_pend_o);
  p_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_vld_o |-> $stable(done_seq_o));
endmodule

// File: tb/retire_ctrl_tb.sv
`timescale 1ns/1ps
module retire_ctrl_tb;
  localparam int SLOTS = 6, CW = 4, SEQ_W = 16, DEPTH = 32, PC_W = 32, INSN = 4;
  localparam logic [31:0] RPC = 32'h100;
  localparam int CNT_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [SLOTS-1:0] b_vld = '0, b_sq = '0, b_ex = '0, b_ft = '0, b_st = '0, b_ld = '0, b_ns = '0;
  logic [SEQ_W-1:0] b_seq [SLOTS];
  logic [SLOTS*SEQ_W-1:0] head_seq;
  logic [CNT_W-1:0] b_used = '0;
  logic b_sp = 1'b0, b_td = 1'b0;

  logic [SLOTS-1:0] retire_o;
  logic nspec_req_o, replay_req_o, trap_req_o, trap_pend_o, free_upd_o, empty_o, done_vld_o;
  logic [SEQ_W-1:0] req_seq_o, done_seq_o;
  logic [CNT_W-1:0] free_cnt_o;
  logic [PC_W-1:0] pc_o, npc_o;

  always_comb for (int i = 0; i < SLOTS; i++) head_seq[i*SEQ_W +: SEQ_W] = b_seq[i];

  retire_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .head_vld_i(b_vld), .head_sq_i(b_sq), .head_exec_i(b_ex), .head_fault_i(b_ft),
    .head_store_i(b_st), .head_load_i(b_ld), .head_nspec_i(b_ns), .head_seq_i(head_seq),
    .rob_used_i(b_used), .stores_pending_i(b_sp), .trap_done_i(b_td),
    .retire_o(retire_o), .nspec_req_o(nspec_req_o), .replay_req_o(replay_req_o),
    .trap_req_o(trap_req_o), .req_seq_o(req_seq_o), .trap_pend_o(trap_pend_o),
    .free_upd_o(free_upd_o), .free_cnt_o(free_cnt_o), .empty_o(empty_o),
    .done_vld_o(done_vld_o), .done_seq_o(done_seq_o), .pc_o(pc_o), .npc_o(npc_o)
  );

  typedef struct {
    logic ns, rp, tr;
    logic [SEQ_W-1:0] rseq;
    logic tp, fupd;
    logic [CNT_W-1:0] fcnt;
    logic emp, dvld;
    logic [SEQ_W-1:0] dseq;
    logic [PC_W-1:0] pc;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_err = 0;
  logic [PC_W-1:0] m_pc = RPC;
  logic m_trap = 1'b0;
  logic [CNT_W-1:0] m_free = CNT_W'(DEPTH);
  logic [SEQ_W-1:0] m_dseq = '0, m_rseq = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, check removal, queue registered results
  task automatic cyc(input logic [SLOTS-1:0] v, sq, ex, ft, st, ld, ns,
                     input logic [SEQ_W-1:0] base, input int used, input logic sp, td);
    logic go, first;
    int nc, nr;
    logic [SLOTS-1:0] ret;
    logic stc;
    int kind;
    logic [SEQ_W-1:0] kseq, young;
    exp_t e;
    @(negedge clk);
    b_vld = v; b_sq = sq; b_ex = ex; b_ft = ft; b_st = st; b_ld = ld; b_ns = ns;
    for (int i = 0; i < SLOTS; i++) b_seq[i] = base + SEQ_W'(i);
    b_used = CNT_W'(used); b_sp = sp; b_td = td;
    #1;
    go = !m_trap; nc = 0; nr = 0; ret = '0; stc = 1'b0; kind = 0; kseq = '0; young = '0;
    for (int i = 0; i < SLOTS; i++) begin
      first = (nc == 0) && !sp;
      if (go) begin
        if (nc == CW || !v[i]) go = 1'b0;
        else if (sq[i]) begin ret[i] = 1'b1; nr++; end
        else if (ex[i] && !ft[i]) begin
          ret[i] = 1'b1; nr++; nc++; young = base + SEQ_W'(i);
          if (st[i]) stc = 1'b1;
        end else begin
          if (first) begin
            if (ft[i]) kind = 3; else if (ns[i]) kind = 1; else if (ld[i]) kind = 2;
            if (kind != 0) kseq = base + SEQ_W'(i);
          end
          go = 1'b0;
        end
      end
    end
    chk("R1/R2 retire_o", 32'(retire_o), 32'(ret));
    e.ns = (kind == 1); e.rp = (kind == 2); e.tr = (kind == 3);
    if (kind != 0) m_rseq = kseq;
    e.rseq = m_rseq;
    if (m_trap && td) m_trap = 1'b0; else if (kind == 3) m_trap = 1'b1;
    e.tp = m_trap;
    e.fupd = (nr != 0);
    if (nr != 0) m_free = CNT_W'(DEPTH - (used - nr));
    e.fcnt = m_free;
    e.emp = ((used - nr) == 0) && !sp && !stc;
    e.dvld = (nc != 0);
    if (nc != 0) m_dseq = young;
    e.dseq = m_dseq;
    m_pc = m_pc + PC_W'(nc * INSN);
    e.pc = m_pc;
    q.push_back(e);
  endtask

  // monitor: compare registered outputs one edge after each driven cycle
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R3 nspec_req", 32'(nspec_req_o), 32'(e.ns));
        chk("R4 replay_req", 32'(replay_req_o), 32'(e.rp));
        chk("R5 trap_req", 32'(trap_req_o), 32'(e.tr));
        if (e.ns || e.rp || e.tr) chk("R3 req_seq", 32'(req_seq_o), 32'(e.rseq));
        chk("R5 trap_pend", 32'(trap_pend_o), 32'(e.tp));
        chk("R8 free_upd", 32'(free_upd_o), 32'(e.fupd));
        chk("R8 free_cnt", 32'(free_cnt_o), 32'(e.fcnt));
        chk("R7 empty", 32'(empty_o), 32'(e.emp));
        chk("R9 done_vld", 32'(done_vld_o), 32'(e.dvld));
        chk("R9 done_seq", 32'(done_seq_o), 32'(e.dseq));
        chk("R6 pc", pc_o, e.pc);
        chk("R6 npc", npc_o, e.pc + INSN);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) b_seq[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // reset state
    chk("R6 reset pc", pc_o, RPC);
    chk("R8 reset free_cnt", 32'(free_cnt_o), DEPTH);
    chk("R7 reset empty", 32'(empty_o), 1);
    chk("R5 reset trap_pend", 32'(trap_pend_o), 0);
    chk("R3 reset reqs", 32'({nspec_req_o, replay_req_o, trap_req_o}), 0);
    // R1: six ready, only four commit
    cyc(6'h3F, 6'h00, 6'h3F, 0, 0, 0, 0, 16'h100, 10, 0, 0);
    // R2: two squashed plus four committed, all six leave; buffer empties (R7)
    cyc(6'h3F, 6'h03, 6'h3F, 0, 0, 0, 0, 16'h200, 6, 0, 0);
    // R1: stop at first unexecuted plain entry
    cyc(6'h3F, 6'h00, 6'h03, 0, 0, 0, 0, 16'h300, 5, 0, 0);
    // R3: non-speculative head requests execution; R8 count holds
    cyc(6'h01, 6'h00, 6'h00, 0, 0, 0, 6'h01, 16'h400, 3, 0, 0);
    // R3: stores pending, no request
    cyc(6'h01, 6'h00, 6'h00, 0, 0, 0, 6'h01, 16'h480, 3, 1, 0);
    // R3: not the first commit, no request
    cyc(6'h03, 6'h00, 6'h01, 0, 0, 0, 6'h02, 16'h500, 3, 0, 0);
    // R4: uncached load replay
    cyc(6'h01, 6'h00, 6'h00, 0, 0, 6'h01, 0, 16'h600, 2, 0, 0);
    // R4: load and non-speculative together, non-speculative wins
    cyc(6'h01, 6'h00, 6'h00, 0, 0, 6'h01, 6'h01, 16'h700, 2, 0, 0);
    // R7: last entry is a store, empty held back
    cyc(6'h01, 6'h00, 6'h01, 0, 6'h01, 0, 0, 16'h800, 1, 0, 0);
    // R7: quiet empty buffer
    cyc(6'h00, 0, 0, 0, 0, 0, 0, 16'h880, 0, 0, 0);
    // R7: empty buffer but stores pending
    cyc(6'h00, 0, 0, 0, 0, 0, 0, 16'h8C0, 0, 1, 0);
    // R5: squashed then faulting entry still counts as first commit
    cyc(6'h03, 6'h01, 6'h02, 6'h02, 0, 0, 0, 16'h900, 2, 0, 0);
    // R5: trap pending blocks ready heads; done releases afterwards
    cyc(6'h03, 6'h00, 6'h03, 0, 0, 0, 0, 16'hA00, 2, 0, 1);
    cyc(6'h03, 6'h00, 6'h03, 0, 0, 0, 0, 16'hB00, 2, 0, 0);
    // R5: fault with stores pending waits
    cyc(6'h01, 6'h00, 6'h00, 6'h01, 0, 0, 0, 16'hC00, 1, 1, 0);
    // R5: fault behind a commit waits
    cyc(6'h03, 6'h00, 6'h01, 6'h02, 0, 0, 0, 16'hD00, 2, 0, 0);
    // R5: executed but faulting entry traps, then done clears
    cyc(6'h01, 6'h00, 6'h01, 6'h01, 0, 0, 0, 16'hE00, 1, 0, 0);
    cyc(6'h00, 0, 0, 0, 0, 0, 0, 16'hE80, 1, 0, 1);
    // R9/R6: mixed run after trap, three commits
    cyc(6'h0F, 6'h00, 6'h07, 0, 6'h02, 0, 0, 16'hF00, 4, 0, 0);
    cyc(6'h00, 0, 0, 0, 0, 0, 0, 16'hF80, 1, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule